// File: doc/BRIEF.md
# Dual-Flag Interrupt Acceptance Controller

This block decides, at each instruction boundary of an 8-bit CPU core, whether an interrupt is taken and which one. It holds two enable bits: a live enable that gates the level-sensitive maskable request, and a saved copy. A falling edge on the active-low non-maskable request is latched and stays pending until a boundary takes it. When an interrupt is taken, the block tells the core to push the program counter and to load a fixed vector. On a return-from-NMI strobe, it tells the core to pop the program counter and copies the saved enable back into the live one.

Taking a non-maskable interrupt clears only the live enable. The saved copy is kept. Because of this, a nested non-maskable handler that returns can turn maskable interrupts back on while the outer handler is still running. The block keeps this behaviour on purpose. A nesting-depth counter reports how deep the non-maskable handlers are. A sticky status bit reports that a maskable interrupt was taken while that depth was non-zero.

A small state machine sequences the core-facing strobes:

- **ST_RUN**: no action; all acceptance decisions are made in this state.
- **ST_NMI_ENTRY**: push the PC and load vector 0x0066. Transition taken: RUN→NMI_ENTRY.
- **ST_INT_ENTRY**: push the PC and load the maskable vector. Transition taken: RUN→INT_ENTRY.
- **ST_RET_EXIT**: pop the PC. Transition taken: RUN→RET_EXIT.

Each of the three entry/exit states lasts one cycle and always returns to ST_RUN.

Top module: `irq_accept_ctl`

## Requirements
- R1: After reset, live_en, saved_en, nest_depth and int_in_nmi are 0, no NMI is pending, and ack_nmi, ack_int, push_pc, load_pc and pop_pc are 0.
- R2: A low pulse on nmi_n, even one clock long, is caught as a falling edge after a two-flop synchronizer. It stays pending until one boundary takes it. A further boundary with no new edge takes nothing.
- R3: A pending NMI is taken whatever the enable bits are. In the cycle after the boundary, ack_nmi, push_pc and load_pc are 1 and pc_vector is 16'h0066. From that cycle on, live_en is 0 and saved_en is unchanged.
- R4: An NMI that arrives while an NMI handler runs (before retn_stb) is taken the same way, and each NMI acceptance raises nest_depth by one.
- R5: A retn_stb cycle is followed by a cycle with pop_pc=1. From that cycle on, live_en equals saved_en. nest_depth falls by one and stays 0 if it was already 0.
- R6: ei_stb sets both live_en and saved_en; di_stb clears both.
- R7: With int_n low and live_en 1, a boundary takes a maskable interrupt. The next cycle has ack_int, push_pc and load_pc at 1 and pc_vector at 16'h0038, and both enable bits are then 0.
- R8: The first boundary after an ei_stb takes no maskable interrupt; the boundary after it may.
- R9: When an NMI is pending and a maskable request is valid at the same boundary, only the NMI is taken.
- R10: No interrupt is taken while boundary is low, however long requests wait.
- R11: With enables set before an outer NMI, an inner NMI followed by retn_stb leaves live_en at 1 inside the outer handler. A held maskable request is then taken at the next boundary, and int_in_nmi becomes 1. int_in_nmi clears when a retn_stb brings nest_depth to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| nmi_n | input | 1 | Active-low non-maskable request (edge) |
| int_n | input | 1 | Active-low maskable request (level) |
| boundary | input | 1 | Instruction boundary; interrupts sampled here |
| ei_stb | input | 1 | Enable-interrupts instruction strobe |
| di_stb | input | 1 | Disable-interrupts instruction strobe |
| retn_stb | input | 1 | Return-from-NMI instruction strobe |
| ack_nmi | output | 1 | Non-maskable entry cycle |
| ack_int | output | 1 | Maskable entry cycle |
| push_pc | output | 1 | Push current PC to stack |
| load_pc | output | 1 | Load pc_vector into PC |
| pc_vector | output | 16 | Entry address to load |
| pop_pc | output | 1 | Pop PC from stack |
| live_en | output | 1 | Live maskable enable |
| saved_en | output | 1 | Saved copy of enable |
| nest_depth | output | 4 | Non-maskable nesting depth |
| int_in_nmi | output | 1 | Maskable taken while depth was non-zero |

## Verification
NMI requests are tried first as a long low level and then as a single-cycle pulse. The single-cycle pulse left unattended for many cycles shows whether the edge latch holds the event or the bench only sees a live level. The same entry sequence is run with enables cleared and with enables set, which separates clearing the live bit from clearing both bits. Coincident NMI and maskable requests test priority, and a boundary straight after EI tests the one-boundary shadow. The nested sequence (outer NMI, inner NMI, RETN, held maskable request) is the only pattern that shows saved-copy restore re-opening maskable interrupts inside a handler.

// File: rtl/irq_accept_pkg.sv
package irq_accept_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_NMI_ENTRY = 2'd1,
        ST_INT_ENTRY = 2'd2,
        ST_RET_EXIT  = 2'd3
    } acc_state_t;

    localparam int unsigned VEC_W = 16;
    localparam logic [VEC_W-1:0] NMI_ENTRY_ADDR = 16'h0066;

endpackage

// File: rtl/irq_nmi_catch.sv
module irq_nmi_catch #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_n,
    input  logic take,
    output logic pending
);
    localparam int unsigned CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;
    logic               fall_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {CHAIN_W{1'b1}};
        end else begin
            chain <= {chain[CHAIN_W-2:0], nmi_n};
        end
    end

    assign fall_seen = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (fall_seen) begin
            pending <= 1'b1;
        end else if (take) begin
            pending <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_enable_flags.sv
module irq_enable_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_take,
    input  logic int_take,
    input  logic retn_do,
    input  logic ei,
    input  logic di,
    input  logic boundary,
    output logic live,
    output logic saved,
    output logic ei_shadow
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            live  <= 1'b0;
            saved <= 1'b0;
        end else if (nmi_take) begin
            live  <= 1'b0;
        end else if (int_take) begin
            live  <= 1'b0;
            saved <= 1'b0;
        end else if (retn_do) begin
            live  <= saved;
        end else if (ei) begin
            live  <= 1'b1;
            saved <= 1'b1;
        end else if (di) begin
            live  <= 1'b0;
            saved <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ei_shadow <= 1'b0;
        end else if (ei) begin
            ei_shadow <= 1'b1;
        end else if (boundary) begin
            ei_shadow <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_nest_depth.sv
module irq_nest_depth #(
    parameter int unsigned DEPTH_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    input  logic               dec,
    input  logic               int_take,
    output logic [DEPTH_W-1:0] depth,
    output logic               int_in_nmi
);
    localparam logic [DEPTH_W-1:0] DEPTH_MAX = {DEPTH_W{1'b1}};
    localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

    logic at_zero;
    assign at_zero = (depth == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            depth <= '0;
        end else if (inc && depth != DEPTH_MAX) begin
            depth <= depth + DEPTH_ONE;
        end else if (dec && !at_zero) begin
            depth <= depth - DEPTH_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_in_nmi <= 1'b0;
        end else if (int_take && !at_zero) begin
            int_in_nmi <= 1'b1;
        end else if (dec && (at_zero || depth == DEPTH_ONE)) begin
            int_in_nmi <= 1'b0;
        end
    end

endmodule

// File: rtl/irq_accept_ctl.sv
module irq_accept_ctl
    import irq_accept_pkg::*;
#(
    parameter int unsigned      DEPTH_W     = 4,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [15:0]      INT_VECTOR  = 16'h0038
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               nmi_n,
    input  logic               int_n,
    input  logic               boundary,
    input  logic               ei_stb,
    input  logic               di_stb,
    input  logic               retn_stb,
    output logic               ack_nmi,
    output logic               ack_int,
    output logic               push_pc,
    output logic               load_pc,
    output logic [15:0]        pc_vector,
    output logic               pop_pc,
    output logic               live_en,
    output logic               saved_en,
    output logic [DEPTH_W-1:0] nest_depth,
    output logic               int_in_nmi
);

    acc_state_t st, st_nx;
    logic       nmi_pend;
    logic       ei_shadow;
    logic       in_run;
    logic       nmi_take;
    logic       int_take;
    logic       retn_do;

    assign in_run   = (st == ST_RUN);
    assign nmi_take = in_run & boundary & nmi_pend;
    assign int_take = in_run & boundary & ~nmi_pend & ~int_n & live_en & ~ei_shadow;
    assign retn_do  = in_run & retn_stb & ~nmi_take & ~int_take;

    irq_nmi_catch #(.SYNC_STAGES(SYNC_STAGES)) u_catch (
        .clk     (clk),
        .rst_n   (rst_n),
        .nmi_n   (nmi_n),
        .take    (nmi_take),
        .pending (nmi_pend)
    );

    irq_enable_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_take  (nmi_take),
        .int_take  (int_take),
        .retn_do   (retn_do),
        .ei        (ei_stb),
        .di        (di_stb),
        .boundary  (boundary),
        .live      (live_en),
        .saved     (saved_en),
        .ei_shadow (ei_shadow)
    );

    irq_nest_depth #(.DEPTH_W(DEPTH_W)) u_depth (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (nmi_take),
        .dec        (retn_do),
        .int_take   (int_take),
        .depth      (nest_depth),
        .int_in_nmi (int_in_nmi)
    );

    always_comb begin
        st_nx = ST_RUN;
        unique case (st)
            ST_RUN: begin
                if (nmi_take)      st_nx = ST_NMI_ENTRY;
                else if (int_take) st_nx = ST_INT_ENTRY;
                else if (retn_do)  st_nx = ST_RET_EXIT;
                else               st_nx = ST_RUN;
            end
            ST_NMI_ENTRY: st_nx = ST_RUN;
            ST_INT_ENTRY: st_nx = ST_RUN;
            ST_RET_EXIT:  st_nx = ST_RUN;
            default:      st_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nx;
    end

    always_comb begin
        ack_nmi   = 1'b0;
        ack_int   = 1'b0;
        push_pc   = 1'b0;
        load_pc   = 1'b0;
        pop_pc    = 1'b0;
        pc_vector = '0;
        unique case (st)
            ST_RUN: ;
            ST_NMI_ENTRY: begin
                ack_nmi   = 1'b1;
                push_pc   = 1'b1;
                load_pc   = 1'b1;
                pc_vector = NMI_ENTRY_ADDR;
            end
            ST_INT_ENTRY: begin
                ack_int   = 1'b1;
                push_pc   = 1'b1;
                load_pc   = 1'b1;
                pc_vector = INT_VECTOR;
            end
            ST_RET_EXIT: pop_pc = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/irq_accept_chk.sv
module irq_accept_chk #(
    parameter int unsigned DEPTH_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               int_n,
    input logic               boundary,
    input logic               ack_nmi,
    input logic               ack_int,
    input logic               push_pc,
    input logic               load_pc,
    input logic [15:0]        pc_vector,
    input logic               pop_pc,
    input logic               live_en,
    input logic               saved_en,
    input logic [DEPTH_W-1:0] nest_depth
);
    localparam logic [DEPTH_W-1:0] DMAX = {DEPTH_W{1'b1}};

    AST_NMI_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |-> (push_pc && load_pc && pc_vector == 16'h0066 && !live_en)); // R3
    AST_NMI_KEEPS_SAVED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |-> (saved_en == $past(saved_en))); // R3
    AST_NMI_DEPTH_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ack_nmi |-> (nest_depth == DEPTH_W'($past(nest_depth) + 1'b1) || $past(nest_depth) == DMAX)); // R4
    AST_RETN_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
        pop_pc |-> (live_en == saved_en)); // R5
    AST_RETN_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_pc && $past(nest_depth) == '0) |-> (nest_depth == '0)); // R5
    AST_INT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_int |-> ($past(live_en) && !$past(int_n) && !live_en && !saved_en)); // R7
    AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ack_nmi, ack_int, pop_pc})); // R9
    AST_BOUNDARY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_nmi || ack_int) |-> $past(boundary)); // R10

endmodule

bind irq_accept_ctl irq_accept_chk #(.DEPTH_W(DEPTH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_n      (int_n),
    .boundary   (boundary),
    .ack_nmi    (ack_nmi),
    .ack_int    (ack_int),
    .push_pc    (push_pc),
    .load_pc    (load_pc),
    .pc_vector  (pc_vector),
    .pop_pc     (pop_pc),
    .live_en    (live_en),
    .saved_en   (saved_en),
    .nest_depth (nest_depth)
);

// File: tb/sim_irq_accept_ctl.sv
`timescale 1ns/1ps
module sim_irq_accept_ctl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic nmi_n = 1'b1, int_n = 1'b1, boundary = 1'b0;
    logic ei_stb = 1'b0, di_stb = 1'b0, retn_stb = 1'b0;
    logic ack_nmi, ack_int, push_pc, load_pc, pop_pc, live_en, saved_en, int_in_nmi;
    logic [15:0] pc_vector;
    logic [3:0]  nest_depth;
    int vectors = 0;
    int miscmp = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_accept_ctl u0 (
        .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .int_n(int_n), .boundary(boundary),
        .ei_stb(ei_stb), .di_stb(di_stb), .retn_stb(retn_stb),
        .ack_nmi(ack_nmi), .ack_int(ack_int), .push_pc(push_pc), .load_pc(load_pc),
        .pc_vector(pc_vector), .pop_pc(pop_pc), .live_en(live_en), .saved_en(saved_en),
        .nest_depth(nest_depth), .int_in_nmi(int_in_nmi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscmp++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic pulse_ei();  ei_stb = 1; tick(); ei_stb = 0; endtask
    task automatic pulse_di();  di_stb = 1; tick(); di_stb = 0; endtask

    // boundary for one cycle; returns sampled in the following entry cycle
    task automatic at_boundary();
        boundary = 1; tick(); boundary = 0;
    endtask

    task automatic nmi_low(input int len);
        nmi_n = 0; repeat (len) tick(); nmi_n = 1; repeat (4) tick();
    endtask

    task automatic do_retn(input string req, input logic [3:0] exp_depth);
        retn_stb = 1; tick(); retn_stb = 0;
        chk({req, " pop_pc"}, pop_pc, 1);
        chk({req, " live==saved"}, live_en, saved_en);
        chk({req, " depth"}, nest_depth, exp_depth);
        tick();
    endtask

    task automatic t_reset();
        chk("R1 live", live_en, 0);
        chk("R1 saved", saved_en, 0);
        chk("R1 depth", nest_depth, 0);
        chk("R1 strobes", {ack_nmi, ack_int, push_pc, load_pc, pop_pc, int_in_nmi}, 0);
        at_boundary();
        chk("R1 no pending nmi", {ack_nmi, ack_int}, 0);
        tick();
    endtask

    task automatic t_ei_di();
        pulse_ei();
        chk("R6 ei", {live_en, saved_en}, 2'b11);
        pulse_di();
        chk("R6 di", {live_en, saved_en}, 2'b00);
    endtask

    task automatic t_nmi_flags_clear();
        nmi_low(3);
        chk("R10 waiting", ack_nmi, 0);
        at_boundary();
        chk("R3 ack", {ack_nmi, push_pc, load_pc}, 3'b111);
        chk("R3 vector", pc_vector, 16'h0066);
        chk("R4 depth1", nest_depth, 1);
        tick();
        at_boundary();
        chk("R2 consumed", ack_nmi, 0);
        tick();
        do_retn("R5 basic", 0);
        do_retn("R5 floor", 0);
    endtask

    task automatic t_nmi_flags_set();
        pulse_ei(); at_boundary(); tick();
        nmi_low(2);
        at_boundary();
        chk("R3 nmi taken", ack_nmi, 1);
        chk("R3 live cleared", live_en, 0);
        chk("R3 saved kept", saved_en, 1);
        tick();
        do_retn("R5 restore", 0);
        chk("R5 live back", live_en, 1);
        pulse_di();
    endtask

    task automatic t_short_pulse();
        nmi_low(1);
        for (int i = 0; i < 12; i++) begin
            chk("R10 idle", {ack_nmi, ack_int}, 0);
            tick();
        end
        at_boundary();
        chk("R2 short pulse held", ack_nmi, 1);
        tick();
        do_retn("R5 after short", 0);
    endtask

    task automatic t_int_and_shadow();
        int_n = 0;
        pulse_ei();
        at_boundary();
        chk("R8 shadow blocks", ack_int, 0);
        repeat (5) begin
            tick();
            chk("R10 int waits", ack_int, 0);
        end
        at_boundary();
        chk("R7 ack", {ack_int, push_pc, load_pc}, 3'b111);
        chk("R7 vector", pc_vector, 16'h0038);
        chk("R7 flags", {live_en, saved_en}, 0);
        int_n = 1; tick();
    endtask

    task automatic t_priority();
        pulse_ei(); at_boundary(); tick();
        int_n = 0;
        nmi_low(2);
        at_boundary();
        chk("R9 nmi wins", {ack_nmi, ack_int}, 2'b10);
        tick();
        do_retn("R9 ret", 0);
        at_boundary();
        chk("R9 int after ret", ack_int, 1);
        chk("R11 flag low at depth0", int_in_nmi, 0);
        int_n = 1; tick();
    endtask

    task automatic t_nested();
        pulse_ei(); at_boundary(); tick();
        nmi_low(2);
        at_boundary();
        chk("R4 outer", ack_nmi, 1);
        tick();
        int_n = 0;
        at_boundary();
        chk("R11 int blocked in outer", ack_int, 0);
        tick();
        nmi_low(2);
        at_boundary();
        chk("R4 inner", ack_nmi, 1);
        chk("R4 depth2", nest_depth, 2);
        tick();
        do_retn("R11 inner ret", 1);
        chk("R11 live reopened", live_en, 1);
        at_boundary();
        chk("R11 int taken in outer", ack_int, 1);
        chk("R11 status", int_in_nmi, 1);
        int_n = 1; tick();
        do_retn("R11 outer ret", 0);
        chk("R11 status cleared", int_in_nmi, 0);
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        t_reset();
        t_ei_di();
        t_nmi_flags_clear();
        t_nmi_flags_set();
        t_short_pulse();
        t_int_and_shadow();
        t_priority();
        t_nested();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            vectors++;
            miscmp++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
            $finish;
        end
    end
endmodule